// File: doc/BRIEF.md
# IP-to-MAC Nibble Lookup Table

This block maps a 32-bit next-hop IPv4 address to the last four bits of a destination MAC address on the egress path. It holds a small table of address keys. Each key carries a 4-bit value. On a lookup, every stored key is compared with the presented address in parallel. The winning entry's 4-bit value is spliced into the local station MAC, which yields the full 48-bit destination MAC for the outgoing frame.

The table is filled once after reset from a stream of 64-bit load words, one per slot, in arrival order. Lookups are refused until every slot holds an entry. A lookup that matches no entry produces a zero nibble and a miss flag, so the packet can be diverted downstream.

Top module: `ipcam_top`

## Requirements
- R1: A load word carries the key in bits [63:32] and the value nibble in bits [3:0]. Bits [31:4] are reserved, and their contents have no effect on any lookup result.
- R2: Load words are written to slots 0, 1, 2 and onward in arrival order. Once all 16 slots are written, further load words are ignored, and a key carried only by an ignored word misses.
- R3: `tbl_ready` is low after reset and goes high in the cycle after the 16th load word is accepted. A lookup presented while `tbl_ready` is low produces no result (`res_valid` stays low).
- R4: A lookup accepted at one rising edge has its result registered at that same edge: `res_valid` is high for exactly that following cycle and low otherwise.
- R5: On a hit, `res_hit` is 1, `res_miss` is 0, `res_nibble` is the stored nibble, and `res_index` is the matching slot number.
- R6: On a miss, `res_miss` is 1, `res_hit` is 0, and both `res_nibble` and `res_index` are 0.
- R7: When several slots hold the presented key, the lowest-numbered slot supplies the index and the nibble.
- R8: `res_mac[47:4]` equals `local_mac[47:4]` as sampled with the lookup, and `res_mac[3:0]` equals `res_nibble`.
- R9: A synchronous reset invalidates every slot, clears the fill count and clears all result outputs. A table loaded afterwards contains no trace of earlier keys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_mac | input | 48 | Station MAC whose upper 44 bits are reused |
| ld_valid | input | 1 | Load word present |
| ld_word | input | 64 | Load word: key, reserved, nibble |
| tbl_ready | output | 1 | All slots loaded; lookups accepted |
| lk_valid | input | 1 | Lookup request |
| lk_ip | input | 32 | Destination IPv4 address to look up |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | A slot matched |
| res_miss | output | 1 | No slot matched |
| res_index | output | 4 | Winning slot number |
| res_nibble | output | 4 | Winning slot's nibble, zero on a miss |
| res_mac | output | 48 | Local MAC with the last nibble replaced |

## Verification
A lookup result is due in the cycle after the edge that samples the request. `tbl_ready` reflects a load one edge after it is accepted. A behavioural model in the bench updates at each rising edge. At that edge it derives the due outputs from the inputs and its own table as they stood before the edge. The design outputs are compared with these values at the following falling edge, so every result is checked in exactly the cycle it is due, and an early or late result shows up as a mismatch.

// File: rtl/ipcam_pkg.sv
package ipcam_pkg;

    localparam int KEY_W  = 32;
    localparam int NIB_W  = 4;
    localparam int MAC_W  = 48;
    localparam int RSV_W  = 28;
    localparam int LOAD_W = KEY_W + RSV_W + NIB_W;

    // Load word layout, most significant field first
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [RSV_W-1:0] rsvd;
        logic [NIB_W-1:0] nib;
    } load_word_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [NIB_W-1:0] nib;
    } slot_data_t;

    function automatic slot_data_t unpack_load(input logic [LOAD_W-1:0] w);
        load_word_t lw;
        slot_data_t sd;
        lw     = load_word_t'(w);
        sd.key = lw.key;
        sd.nib = lw.nib;
        return sd;
    endfunction

    function automatic logic [MAC_W-1:0] splice_mac(input logic [MAC_W-1:0] base,
                                                     input logic [NIB_W-1:0] nib);
        return {base[MAC_W-1:NIB_W], nib};
    endfunction

endpackage

// File: rtl/ipcam_loader.sv
module ipcam_loader
    import ipcam_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [LOAD_W-1:0] ld_word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_slot,
    output slot_data_t        wr_data,
    output logic              full
);

    logic [CNT_W-1:0] fill_cnt;

    assign full    = (fill_cnt == CNT_W'(SLOTS));
    assign wr_en   = ld_valid && !full;
    assign wr_slot = IDX_W'(fill_cnt);
    assign wr_data = unpack_load(ld_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
        end else if (wr_en) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(SLOTS));

    assert_full_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        (full && ld_valid) |=> $stable(fill_cnt));

    assert_ready_holds_R3: assert property (@(posedge clk) disable iff (rst)
        full |=> full);

endmodule

// File: rtl/ipcam_store.sv
module ipcam_store
    import ipcam_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  slot_data_t             wr_data,
    input  logic [KEY_W-1:0]       lk_key,
    output logic [SLOTS-1:0]       match,
    output logic [SLOTS*NIB_W-1:0] nib_flat
);

    logic [SLOTS-1:0] slot_valid;
    slot_data_t       slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[s] <= 1'b0;
                slot_q[s]     <= '0;
            end else if (wr_en && wr_slot == IDX_W'(s)) begin
                slot_valid[s] <= 1'b1;
                slot_q[s]     <= wr_data;
            end
        end

        assign match[s] = slot_valid[s] && (slot_q[s].key == lk_key);
        assign nib_flat[s*NIB_W +: NIB_W] = slot_q[s].nib;
    end

    assert_slot_written_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_valid[$past(wr_slot)]);

    assert_match_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (match & ~slot_valid) == '0);

endmodule

// File: rtl/ipcam_prio.sv
module ipcam_prio #(
    parameter int SLOTS = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] match,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is assigned last
    always_comb begin
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;

    always_comb begin
        if (hit) begin
            assert_lowest_wins_R7: assert (match[idx] && ((match & ((SLOTS'(1) << idx) - SLOTS'(1))) == '0));
        end
    end

endmodule

// File: rtl/ipcam_top.sv
module ipcam_top
    import ipcam_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MAC_W-1:0]  local_mac,
    input  logic              ld_valid,
    input  logic [LOAD_W-1:0] ld_word,
    output logic              tbl_ready,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_ip,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [IDX_W-1:0]  res_index,
    output logic [NIB_W-1:0]  res_nibble,
    output logic [MAC_W-1:0]  res_mac
);

    logic                   wr_en;
    logic [IDX_W-1:0]       wr_slot;
    slot_data_t             wr_data;
    logic [SLOTS-1:0]       match;
    logic [SLOTS*NIB_W-1:0] nib_flat;
    logic                   hit_c;
    logic [IDX_W-1:0]       idx_c;
    logic [NIB_W-1:0]       nib_c;
    logic                   accept;

    ipcam_loader #(.SLOTS(SLOTS)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .ld_valid(ld_valid),
        .ld_word (ld_word),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .full    (tbl_ready)
    );

    ipcam_store #(.SLOTS(SLOTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .lk_key  (lk_ip),
        .match   (match),
        .nib_flat(nib_flat)
    );

    ipcam_prio #(.SLOTS(SLOTS)) u_prio (
        .match(match),
        .hit  (hit_c),
        .idx  (idx_c)
    );

    assign accept = lk_valid && tbl_ready;
    assign nib_c  = hit_c ? nib_flat[idx_c*NIB_W +: NIB_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_index  <= '0;
            res_nibble <= '0;
            res_mac    <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_hit    <= hit_c;
                res_miss   <= !hit_c;
                res_index  <= hit_c ? idx_c : '0;
                res_nibble <= nib_c;
                res_mac    <= splice_mac(local_mac, nib_c);
            end
        end
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && tbl_ready) |=> res_valid);

    assert_refused_R3: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && tbl_ready) |=> !res_valid);

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_miss) |-> (res_nibble == '0 && res_index == '0 && !res_hit));

    assert_mac_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && tbl_ready) |=> (res_mac[MAC_W-1:NIB_W] == $past(local_mac[MAC_W-1:NIB_W])));

    assert_mac_nibble_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_mac[NIB_W-1:0] == res_nibble));

endmodule

// File: tb/ipcam_top_bench.sv
module ipcam_top_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [47:0] local_mac;
    logic        ld_valid;
    logic [63:0] ld_word;
    logic        tbl_ready;
    logic        lk_valid;
    logic [31:0] lk_ip;
    logic        res_valid, res_hit, res_miss;
    logic [3:0]  res_index, res_nibble;
    logic [47:0] res_mac;

    always #2 clk = ~clk;   // 250 MHz

    ipcam_top u_ipcam_top (
        .clk(clk), .rst(rst), .local_mac(local_mac),
        .ld_valid(ld_valid), .ld_word(ld_word), .tbl_ready(tbl_ready),
        .lk_valid(lk_valid), .lk_ip(lk_ip),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_index(res_index), .res_nibble(res_nibble), .res_mac(res_mac)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference model
    logic [31:0] m_key [N];
    logic [3:0]  m_nib [N];
    int          m_cnt;
    logic        e_ready, e_valid, e_hit, e_miss;
    logic [3:0]  e_index, e_nib;
    logic [47:0] e_mac;

    initial begin
        m_cnt = 0;
        e_ready = 0; e_valid = 0; e_hit = 0; e_miss = 0;
        e_index = 0; e_nib = 0; e_mac = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            e_valid = 0; e_hit = 0; e_miss = 0;
            e_index = 0; e_nib = 0; e_mac = 0;
        end else begin
            e_valid = lk_valid && (m_cnt == N);
            if (e_valid) begin
                int found;
                found = -1;
                for (int i = 0; i < N; i++)
                    if (found < 0 && m_key[i] == lk_ip) found = i;
                e_hit   = (found >= 0);
                e_miss  = !e_hit;
                e_index = e_hit ? 4'(found) : 4'd0;
                e_nib   = e_hit ? m_nib[found] : 4'd0;
                e_mac   = {local_mac[47:4], e_nib};
            end
            if (ld_valid && m_cnt < N) begin
                m_key[m_cnt] = ld_word[63:32];
                m_nib[m_cnt] = ld_word[3:0];
                m_cnt = m_cnt + 1;
            end
        end
        e_ready = (m_cnt == N);
    end

    task automatic chk(input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst === 1'b0) begin
            chk("R3", "tbl_ready", 48'(tbl_ready), 48'(e_ready));
            chk("R4", "res_valid", 48'(res_valid), 48'(e_valid));
            if (e_valid) begin
                chk("R5", "res_hit",    48'(res_hit),    48'(e_hit));
                chk("R6", "res_miss",   48'(res_miss),   48'(e_miss));
                chk("R7", "res_index",  48'(res_index),  48'(e_index));
                chk("R5", "res_nibble", 48'(res_nibble), 48'(e_nib));
                chk("R8", "res_mac",    res_mac,         e_mac);
            end
        end
    end

    function automatic logic [63:0] mk(input logic [31:0] key, input logic [3:0] nib,
                                       input int salt);
        // R1: key high, reserved bits filled with junk, nibble low
        return {key, 28'(32'hA5C3_0F1 ^ (salt * 32'h1357)), nib};
    endfunction

    task automatic load(input logic [63:0] w);
        ld_valid = 1; ld_word = w;
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic look(input logic [31:0] ip);
        lk_valid = 1; lk_ip = ip;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic do_reset;
        rst = 1;
        repeat (2) @(negedge clk);
        // R9: cleared outputs right after reset
        chk("R9", "ready after reset", 48'(tbl_ready), 48'd0);
        chk("R9", "valid after reset", 48'(res_valid), 48'd0);
        chk("R9", "nibble after reset", 48'(res_nibble), 48'd0);
        rst = 0;
    endtask

    initial begin
        rst = 1; ld_valid = 0; ld_word = 0; lk_valid = 0; lk_ip = 0;
        local_mac = 48'h0A02_0102_0304;
        @(negedge clk);
        do_reset();

        // R3: lookup refused while table is filling
        look(32'hC0A8_0001);
        for (int i = 0; i < N; i++) begin
            logic [31:0] k;
            k = 32'hC0A8_0000 + 32'(i);
            if (i == 9) k = 32'hC0A8_0005;       // R7: duplicate of slot 5
            load(mk(k, 4'(i ^ 4'h6), i));
            if (i == 7) look(32'hC0A8_0000);     // still refused, R3
        end
        // R2: overflow word ignored
        load(mk(32'hDEAD_BEEF, 4'hF, 99));
        look(32'hDEAD_BEEF);
        // R5: every slot, back to back
        lk_valid = 1;
        for (int i = 0; i < N; i++) begin
            lk_ip = 32'hC0A8_0000 + 32'(i);
            @(negedge clk);
        end
        lk_valid = 0;
        // R6: misses, R8: new local MAC
        local_mac = 48'h1122_3344_5566;
        look(32'h0A00_0001);
        look(32'hC0A8_0005);                     // R7 lowest slot wins
        look(32'hC0A8_000F);
        // load+lookup in same cycle after full
        ld_valid = 1; ld_word = mk(32'h0101_0101, 4'h9, 3);
        lk_valid = 1; lk_ip = 32'h0101_0101;
        @(negedge clk);
        ld_valid = 0; lk_valid = 0;
        @(negedge clk);

        // R9: reset wipes the table; reload with different keys
        do_reset();
        for (int i = 0; i < N; i++) load(mk(32'h0A0A_0000 + 32'(i * 3), 4'(15 - i), i + 40));
        look(32'hC0A8_0003);                     // old key must miss
        look(32'h0A0A_0009);                     // slot 3 hit
        look(32'h0A0A_002D);                     // slot 15 hit
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule